// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block divides a fast input clock by a programmable integer ratio. It builds that ratio from a small prescaler that counts periods of either 8 or 9 input cycles. Two down-counters steer it. The swallow count `A` (3 bits) sets how many of the prescaler periods in a division cycle are stretched to 9 cycles. The main count `M` (11 bits) sets how many prescaler periods make up one division cycle. The overall ratio is therefore 8·M + A. Every integer from 56 upward can be reached, and the largest ratio is 16383.

A programming interface drives a level-sensitive hold input. While hold is high, the A and M values present on the inputs are captured, all counters sit in their start state and the output is silenced. The values present when hold falls are the ones used. Once hold is low, the counters run and the inputs are ignored until the next hold pulse. The output produces one pulse, eight input cycles wide, per division cycle, for use by a phase comparator.

Top module: `pulse_swallow_div`

## Requirements
- R1: After `rst_ni` is released, `pulse_o` stays low until a first hold pulse has been applied and removed.
- R2: While `hold_i` is high, `pulse_o` is low from the following cycle on. The `a_i`/`m_i` values present at the last clock edge with `hold_i` high are the ones used.
- R3: With A ≤ M, the distance between consecutive rising edges of `pulse_o` is 8·M + A input cycles.
- R4: Each pulse on `pulse_o` is high for exactly 8 consecutive input cycles.
- R5: Number the cycle after the last edge that samples `hold_i` high as cycle 0. The first rising edge of `pulse_o` then appears at cycle R − L, where R is the ratio and L is the length of the final prescaler period (9 when every period is stretched, otherwise 8). Stretched periods come first in each division cycle.
- R6: When A > M, every prescaler period is stretched, so the ratio becomes 9·M.
- R7: The boundary values A = 0 and A = M give ratios of exactly 8·M and 9·M.
- R8: Changes on `a_i` or `m_i` while `hold_i` is low have no effect on the division ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Synchronous hold: captures A/M and keeps counters in start state |
| a_i | input | 3 | Swallow count A (stretched periods per division cycle) |
| m_i | input | 11 | Main count M (prescaler periods per division cycle) |
| pulse_o | output | 1 | Divided output, one 8-cycle pulse per division cycle |

## Verification
The bench builds the block with its default widths: a 3-bit swallow count, an 11-bit main count and a base modulus of 8. With these widths it reaches both ends of the ratio range. The lowest fully steppable ratio, 56 (M = 7, A = 0), is measured, and so is the largest ratio, 16383 (M = 2047, A = 7). Out-of-range cases A > M and A = M show the all-stretched behaviour. Ratios well below 56 (M = 2, 3) confirm that the pulse timing still holds when few prescaler periods remain.

// File: rtl/psd_pkg.sv
package psd_pkg;

  localparam int unsigned PSD_A_W  = 3;
  localparam int unsigned PSD_M_W  = 11;
  localparam int unsigned PSD_BASE = 8;

  // Width of a counter that must hold values 0 .. base (the stretched period).
  function automatic int unsigned psd_pre_w(input int unsigned base);
    return $clog2(base + 1);
  endfunction

  // Number of stretched periods actually used in one division cycle.
  function automatic int unsigned psd_stretched(input int unsigned m, input int unsigned a);
    return (a > m) ? m : a;
  endfunction

  // Total division ratio for a given M and A.
  function automatic int unsigned psd_ratio(input int unsigned m, input int unsigned a,
                                            input int unsigned base);
    return base * m + psd_stretched(m, a);
  endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned BASE = 8,
  parameter int unsigned PC_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            stretch_i,
  output logic [PC_W-1:0] cnt_o,
  output logic            wrap_o,
  output logic            win_o
);

  localparam logic [PC_W-1:0] LAST_SHORT = PC_W'(BASE - 1);
  localparam logic [PC_W-1:0] LAST_LONG  = PC_W'(BASE);

  logic [PC_W-1:0] cnt_q;

  assign wrap_o = !clr_i && (cnt_q == (stretch_i ? LAST_LONG : LAST_SHORT));
  assign win_o  = (cnt_q < LAST_LONG);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || wrap_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/psd_swallow_ctr.sv
module psd_swallow_ctr #(
  parameter int unsigned A_W = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [A_W-1:0] load_val_i,
  input  logic           step_i,
  output logic           stretch_o
);

  logic [A_W-1:0] left_q;

  assign stretch_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= load_val_i;
    end else if (step_i && stretch_o) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/psd_main_ctr.sv
module psd_main_ctr #(
  parameter int unsigned M_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [M_W-1:0] load_val_i,
  input  logic           step_i,
  output logic           last_o
);

  logic [M_W-1:0] left_q;

  assign last_o = (left_q <= M_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
    end else if (load_i) begin
      left_q <= load_val_i;
    end else if (step_i) begin
      left_q <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int unsigned A_W  = PSD_A_W,
  parameter int unsigned M_W  = PSD_M_W,
  parameter int unsigned BASE = PSD_BASE
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hold_i,
  input  logic [A_W-1:0] a_i,
  input  logic [M_W-1:0] m_i,
  output logic           pulse_o
);

  localparam int unsigned PC_W = psd_pre_w(BASE);

  // Captured settings, updated only while hold is high.
  logic [A_W-1:0] cfg_a_q;
  logic [M_W-1:0] cfg_m_q;
  logic           armed_q;
  logic           run_q;

  // Named internal events, also observed by the checker.
  logic [PC_W-1:0] pre_cnt;
  logic            pre_wrap;
  logic            pre_win;
  logic            stretch;
  logic            last_per;
  logic            per_end;
  logic            cyc_end;
  logic            ctr_load;
  logic            ctr_step;
  logic [A_W-1:0]  load_a;
  logic [M_W-1:0]  load_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_a_q <= '0;
      cfg_m_q <= '0;
      armed_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      if (hold_i) begin
        cfg_a_q <= a_i;
        cfg_m_q <= m_i;
      end
      armed_q <= armed_q | hold_i;
      run_q   <= armed_q & ~hold_i;
    end
  end

  assign per_end  = pre_wrap & ~hold_i;
  assign cyc_end  = per_end & last_per;
  assign ctr_load = hold_i | cyc_end;
  assign ctr_step = per_end & ~last_per;
  assign load_a   = hold_i ? a_i : cfg_a_q;
  assign load_m   = hold_i ? m_i : cfg_m_q;

  psd_prescaler #(
    .BASE (BASE),
    .PC_W (PC_W)
  ) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (hold_i),
    .stretch_i (stretch),
    .cnt_o     (pre_cnt),
    .wrap_o    (pre_wrap),
    .win_o     (pre_win)
  );

  psd_swallow_ctr #(
    .A_W (A_W)
  ) u_swl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load),
    .load_val_i (load_a),
    .step_i     (ctr_step),
    .stretch_o  (stretch)
  );

  psd_main_ctr #(
    .M_W (M_W)
  ) u_main (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ctr_load),
    .load_val_i (load_m),
    .step_i     (ctr_step),
    .last_o     (last_per)
  );

  assign pulse_o = run_q & last_per & pre_win;

endmodule

// File: rtl/pulse_swallow_div_chk.sv
module pulse_swallow_div_chk #(
  parameter int unsigned A_W  = 3,
  parameter int unsigned BASE = 8,
  parameter int unsigned PC_W = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            hold_i,
  input logic            pulse_o,
  input logic [PC_W-1:0] pre_cnt,
  input logic            stretch,
  input logic            cyc_end,
  input logic [A_W-1:0]  cfg_a_q
);

  localparam int unsigned HL_W = $clog2(BASE + 2);

  logic [HL_W-1:0] hi_len;
  logic            hold_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len <= '0;
      hold_d <= 1'b0;
    end else begin
      hold_d <= hold_i;
      if (!pulse_o) begin
        hi_len <= '0;
      end else if (hi_len != {HL_W{1'b1}}) begin
        hi_len <= hi_len + 1'b1;
      end
    end
  end

  // R2: hold silences the output from the next cycle
  a_r2_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !pulse_o);

  // R4: a pulse never runs longer than one base period
  a_r4_width_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_len <= HL_W'(BASE));

  // R4: a pulse ended without hold was exactly one base period long
  a_r4_width_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && hi_len != '0 && !hold_d) |-> (hi_len == HL_W'(BASE)));

  // R5: stretched periods end only at a period boundary
  a_r5_stretch_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stretch) |-> (pre_cnt == '0));

  // R3: an unstretched period never reaches the extra count
  a_r3_short_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stretch |-> (pre_cnt < PC_W'(BASE)));

  // R3: a new division cycle restarts stretching from the captured swallow count
  a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_end |=> (stretch == (cfg_a_q != '0)));

endmodule

bind pulse_swallow_div pulse_swallow_div_chk #(
  .A_W  (A_W),
  .BASE (BASE),
  .PC_W (PC_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hold_i  (hold_i),
  .pulse_o (pulse_o),
  .pre_cnt (pre_cnt),
  .stretch (stretch),
  .cyc_end (cyc_end),
  .cfg_a_q (cfg_a_q)
);

// File: tb/pulse_swallow_div_tb.sv
module pulse_swallow_div_tb;

  localparam int PERIOD = 10;
  localparam int NV     = 6;
  localparam int VEC [NV][2] = '{'{7, 0}, '{7, 3}, '{10, 3}, '{12, 5}, '{2, 1}, '{3, 0}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hold = 1'b0;
  logic [2:0]  a_v = '0;
  logic [10:0] m_v = '0;
  logic        pulse;

  int checks = 0;
  int errors = 0;

  always #(PERIOD / 2) clk = ~clk;

  pulse_swallow_div u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .hold_i  (hold),
    .a_i     (a_v),
    .m_i     (m_v),
    .pulse_o (pulse)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Hold with (m0,a0), then (m,a), release; optionally change inputs while running.
  task automatic run_case(input int m0, input int a0, input int m, input int a,
                          input bit chg, input int m2, input int a2, input string req);
    int used, ratio, lastlen, first, lim;
    int r1, r2, r3, w;
    bit prev, cur;
    used    = (a > m) ? m : a;
    ratio   = (a > m) ? 9 * m : 8 * m + a;
    lastlen = (used == m) ? 9 : 8;
    first   = ratio - lastlen;
    lim     = first + 2 * ratio + 20;
    @(negedge clk);
    hold = 1'b1; m_v = 11'(m0); a_v = 3'(a0);
    repeat (2) @(negedge clk);
    m_v = 11'(m); a_v = 3'(a);
    repeat (2) @(negedge clk);
    hold = 1'b0;
    r1 = -1; r2 = -1; r3 = -1; w = 0; prev = 1'b0;
    for (int k = 0; k < lim && r3 < 0; k++) begin
      if (k > 0) @(negedge clk);
      if (chg && k == 5) begin
        m_v = 11'(m2); a_v = 3'(a2);
      end
      cur = pulse;
      if (cur && !prev) begin
        if (r1 < 0) r1 = k;
        else if (r2 < 0) r2 = k;
        else r3 = k;
      end
      if (r1 >= 0 && r2 < 0 && cur) w++;
      prev = cur;
    end
    check("R5", $sformatf("first rise m=%0d a=%0d", m, a), r1, first);
    check("R4", $sformatf("width m=%0d a=%0d", m, a), w, 8);
    check(req, $sformatf("period1 m=%0d a=%0d", m, a), r2 - r1, ratio);
    check(req, $sformatf("period2 m=%0d a=%0d", m, a), r3 - r2, ratio);
  endtask

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int highs;
    int guard;
    // R1: reset state and idle before any hold pulse
    repeat (3) @(negedge clk);
    check("R1", "pulse in reset", int'(pulse), 0);
    rst_n = 1'b1;
    highs = 0;
    repeat (40) begin
      @(negedge clk);
      if (pulse) highs++;
    end
    check("R1", "pulse before first hold", highs, 0);

    // R3: table of ratios
    for (int i = 0; i < NV; i++)
      run_case(VEC[i][0], VEC[i][1], VEC[i][0], VEC[i][1], 1'b0, 0, 0, "R3");

    // R7: boundaries A=0 and A=M
    run_case(9, 0, 9, 0, 1'b0, 0, 0, "R7");
    run_case(7, 7, 7, 7, 1'b0, 0, 0, "R7");
    // R6: A greater than M
    run_case(3, 5, 3, 5, 1'b0, 0, 0, "R6");
    // R2: last value before release wins
    run_case(5, 5, 9, 2, 1'b0, 0, 0, "R2");
    // R8: input changes while running are ignored
    run_case(10, 3, 10, 3, 1'b1, 20, 1, "R8");
    // R3: largest ratio
    run_case(2047, 7, 2047, 7, 1'b0, 0, 0, "R3");

    // R2: hold during a pulse silences it and keeps it silent
    guard = 0;
    while (!pulse && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check("R2", "pulse seen before hold", int'(pulse), 1);
    hold = 1'b1;
    @(negedge clk);
    check("R2", "pulse after hold edge", int'(pulse), 0);
    highs = 0;
    repeat (30) begin
      @(negedge clk);
      if (pulse) highs++;
    end
    check("R2", "pulse during long hold", highs, 0);
    hold = 1'b0;
    repeat (5) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule